// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

A supervisor that counts down a 7-bit value on a slow tick and asks for a system reset when software stops refreshing it. The tick comes from a fixed clock divider followed by a power-of-two prescaler of 1, 2, 4 or 8. The counter times out when it steps down from 0x40. A refresh is a write of a new counter value, and it is accepted only once the counter has fallen to the programmed window value or below. A refresh written too early is treated as a fault.

Software talks to the block through a small word-wide register port. It can start the watchdog, refresh the counter, choose the prescaler, the window and the interrupt enable, and clear the early-warning flag. The flag rises one tick before timeout, so an interrupt handler can still act before the reset comes. Once started, the watchdog stays running until a reset. Any fault it detects produces a one-cycle reset pulse, and at the same time the block puts itself back into its power-on state.

Top module: `win_wdog_top`

## Requirements
- R1: After rst_ni the block is stopped. Counter and window read 0x7F, prescale is 0, interrupt enable and flag are 0, and sys_rst_o and irq_o are low.
- R2: While running, the counter drops by exactly one every FIX_DIV*2^prescale clock cycles. It holds its value while stopped. Starting the watchdog and every accepted refresh restart this tick phase, so the first decrement lands one full tick period later.
- R3: When a tick arrives with the counter at 0x40, sys_rst_o is high for exactly one cycle. For a load value v, this happens ((v & 0x3F) + 1) tick periods after the start or refresh.
- R4: While running, a counter write with a value below 0x40 (bit 6 clear) produces the reset pulse on the next cycle.
- R5: While running, a counter write when the current count is above the window value produces the reset pulse. A write when the count is at or below the window reloads the counter and gives no pulse.
- R6: Writing 0 to the start bit has no effect on a running watchdog. Writing 1 to the start bit while stopped and the counter below 0x40 produces the reset pulse.
- R7: The early flag sets when the counter reaches 0x40 by decrement. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. irq_o equals the flag AND the interrupt enable.
- R8: In the cycle where sys_rst_o is high, every register is back at its R1 value.
- R9: Register map, with addresses on reg_addr_i. Address 0 is control: bit 0 starts the watchdog and reads back the running state. Address 1 is the counter, bits 6:0. Address 2 is configuration: window in bits 6:0, prescale in bits 8:7, interrupt enable in bit 9. Address 3 is status: bit 0 is the early flag. Read data is combinational on reg_addr_i.
- R10: While stopped, a counter write loads any value, including one below 0x40, without a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W (16) | Write data |
| reg_rdata_o | output | DATA_W (16) | Read data for reg_addr_i |
| sys_rst_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
The timeout path is swept over every load value from 0x40 to 0x7F at prescale 0 and 1, and over spot values at prescale 2 and 3. On every cycle the bench compares the counter read-back and the interrupt with their arithmetic values, which separates errors in the tick period, in the decrement and in the 0x40 boundary. Refresh writes are placed at counts of exactly one above the window and exactly at the window, which isolates the window comparison. Other patterns cover a write below 0x40, starting with a counter below 0x40, a write of 0 to the start bit, and status writes of 0 and 1. These check the fault sources and the flag clearing one at a time.

// File: rtl/win_wdog_pkg.sv
`timescale 1ns/1ps
package win_wdog_pkg;
  localparam int CNT_W  = 7;
  localparam int PSC_W  = 2;
  localparam int ADDR_W = 2;
  localparam logic [CNT_W-1:0] CNT_FLOOR = 7'h40;
  localparam logic [CNT_W-1:0] CNT_DEF   = 7'h7F;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_CNT  = 2'd1,
    A_CFG  = 2'd2,
    A_STAT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/win_wdog_tick.sv
`timescale 1ns/1ps
module win_wdog_tick
  import win_wdog_pkg::*;
#(
  parameter int FIX_DIV = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int DIV_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam int PRE_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [PRE_W-1:0] pre_q, pre_mask;
  logic             div_last;

  assign div_last = (div_q == DIV_W'(FIX_DIV - 1));
  assign pre_mask = PRE_W'((1 << psc_i) - 1);
  assign tick_o   = run_i && div_last && ((pre_q & pre_mask) == pre_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      pre_q <= '0;
    end else if (!run_i || restart_i) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_last ? '0 : div_q + 1'b1;
      if (div_last) pre_q <= pre_q + 1'b1;
    end
  end

  generate
    if (FIX_DIV > 1) begin : g_gap
      assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o)
        else $error("tick on consecutive cycles");
    end
  endgenerate
endmodule

// File: rtl/win_wdog_core.sv
`timescale 1ns/1ps
module win_wdog_core
  import win_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_we_i,
  input  logic             start_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] window_i,
  output logic             en_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bite_o,
  output logic             restart_o,
  output logic             hit_floor_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;
  logic             too_early, too_low, expire, bad_start;

  assign too_early = cnt_we_i && en_q && (cnt_q > window_i);
  assign too_low   = cnt_we_i && en_q && !wdata_i[CNT_W-1];
  assign expire    = en_q && tick_i && !cnt_we_i && (cnt_q == CNT_FLOOR);
  assign bad_start = start_we_i && !en_q && !cnt_q[CNT_W-1];
  assign bite_o    = too_early || too_low || expire || bad_start;

  assign restart_o   = cnt_we_i;
  assign hit_floor_o = en_q && tick_i && !cnt_we_i && (cnt_q == CNT_FLOOR + 7'd1);
  assign en_o        = en_q;
  assign cnt_o       = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= CNT_DEF;
    end else if (bite_o) begin
      en_q  <= 1'b0;
      cnt_q <= CNT_DEF;
    end else begin
      if (start_we_i) en_q <= 1'b1;
      if (cnt_we_i)            cnt_q <= wdata_i;
      else if (en_q && tick_i) cnt_q <= cnt_q - 7'd1;
    end
  end

  assert_sticky_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !bite_o) |=> en_q)
    else $error("enable dropped without a bite");

  assert_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |-> cnt_q[CNT_W-1])
    else $error("running counter below floor");

  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && tick_i && !cnt_we_i && !bite_o) |=> (cnt_q == $past(cnt_q) - 7'd1))
    else $error("counter did not step by one");

  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cnt_we_i && !bite_o) |=> $stable(cnt_q))
    else $error("stopped counter moved");
endmodule

// File: rtl/win_wdog_irq.sv
`timescale 1ns/1ps
module win_wdog_irq
  import win_wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             clr_i,
  input  logic             ie_i,
  input  logic             bite_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             flag_o,
  output logic             irq_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (bite_i) flag_q <= 1'b0;
    else if (hit_i)  flag_q <= 1'b1;  // set beats clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && ie_i;

  assert_flag_origin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> (cnt_i == CNT_FLOOR))
    else $error("flag set away from floor");
endmodule

// File: rtl/win_wdog_top.sv
`timescale 1ns/1ps
module win_wdog_top
  import win_wdog_pkg::*;
#(
  parameter int FIX_DIV = 4096,
  parameter int DATA_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sys_rst_o,
  output logic              irq_o
);
  localparam int PSC_LSB = CNT_W;
  localparam int IE_BIT  = CNT_W + PSC_W;

  logic             we_ctrl, we_cnt, we_cfg, we_stat;
  logic [CNT_W-1:0] window_q, cnt;
  logic [PSC_W-1:0] psc_q;
  logic             ie_q, en, bite, restart, tick, hit, flag, rst_q;
  logic             unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:IE_BIT+1];

  assign we_ctrl = reg_we_i && (reg_addr_e'(reg_addr_i) == A_CTRL);
  assign we_cnt  = reg_we_i && (reg_addr_e'(reg_addr_i) == A_CNT);
  assign we_cfg  = reg_we_i && (reg_addr_e'(reg_addr_i) == A_CFG);
  assign we_stat = reg_we_i && (reg_addr_e'(reg_addr_i) == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      window_q <= CNT_DEF;
      psc_q    <= '0;
      ie_q     <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_q <= bite;
      if (bite) begin
        window_q <= CNT_DEF;
        psc_q    <= '0;
        ie_q     <= 1'b0;
      end else if (we_cfg) begin
        window_q <= reg_wdata_i[CNT_W-1:0];
        psc_q    <= reg_wdata_i[PSC_LSB +: PSC_W];
        ie_q     <= reg_wdata_i[IE_BIT];
      end
    end
  end

  win_wdog_tick #(.FIX_DIV(FIX_DIV)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en),
    .restart_i (restart),
    .psc_i     (psc_q),
    .tick_o    (tick)
  );

  win_wdog_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .cnt_we_i    (we_cnt),
    .start_we_i  (we_ctrl && reg_wdata_i[0]),
    .wdata_i     (reg_wdata_i[CNT_W-1:0]),
    .window_i    (window_q),
    .en_o        (en),
    .cnt_o       (cnt),
    .bite_o      (bite),
    .restart_o   (restart),
    .hit_floor_o (hit)
  );

  win_wdog_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .clr_i  (we_stat && reg_wdata_i[0]),
    .ie_i   (ie_q),
    .bite_i (bite),
    .cnt_i  (cnt),
    .flag_o (flag),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      A_CTRL: reg_rdata_o[0]         = en;
      A_CNT:  reg_rdata_o[CNT_W-1:0] = cnt;
      A_CFG: begin
        reg_rdata_o[CNT_W-1:0]        = window_q;
        reg_rdata_o[PSC_LSB +: PSC_W] = psc_q;
        reg_rdata_o[IE_BIT]           = ie_q;
      end
      default: reg_rdata_o[0] = flag;
    endcase
  end

  assign sys_rst_o = rst_q;

  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o)
    else $error("reset pulse longer than one cycle");

  assert_defaults_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (!en && cnt == CNT_DEF && window_q == CNT_DEF && psc_q == '0 && !ie_q && !flag))
    else $error("state not restored with reset pulse");
endmodule

// File: tb/win_wdog_top_test.sv
`timescale 1ns/1ps
module win_wdog_top_test;
  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0, rdata, d;
  logic        sys_rst, irq;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  win_wdog_top #(.FIX_DIV(4)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sys_rst_o(sys_rst), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; write takes effect at the next posedge
  task automatic wr(input logic [1:0] a, input int v);
    we = 1'b1; addr = a; wdata = 16'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic run_timeout(input int v, input int psc, input int ie);
    int p, t, bad, ea, aa, ec;
    p = 4 << psc; t = ((v & 63) + 1) * p; bad = 0; ea = 0; aa = 0;
    wr(2, (ie << 9) | (psc << 7) | 'h7F);
    wr(1, v);
    wr(0, 1);
    addr = 1;
    for (int k = 0; k < t; k++) begin
      #1;
      ec = v - k / p;
      if (sys_rst !== 1'b0 || int'(rdata[6:0]) != ec ||
          irq !== ((ie != 0) && v > 64 && ec == 64)) begin
        bad++; ea = ec; aa = int'(rdata[6:0]);
      end
      @(negedge clk);
    end
    chk(bad == 0, $sformatf("R2 R7 count/irq trace v=%0h psc=%0d", v, psc), aa, ea);
    #1;
    chk(sys_rst === 1'b1, $sformatf("R3 timeout pulse v=%0h psc=%0d", v, psc), sys_rst, 1);
    chk(rdata[6:0] == 7'h7F, "R8 counter default at pulse", rdata[6:0], 'h7F);
    @(negedge clk); #1;
    chk(sys_rst === 1'b0, "R3 pulse single cycle", sys_rst, 0);
  endtask

  task automatic poll_cnt(input int target);
    for (int i = 0; i < 400; i++) begin
      rd(1, d);
      if (int'(d[6:0]) == target) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R9 reset state
    rd(0, d); chk(d == 0, "R1 control after reset", d, 0);
    rd(1, d); chk(d == 16'h7F, "R1 counter after reset", d, 'h7F);
    rd(2, d); chk(d == 16'h7F, "R1 config after reset", d, 'h7F);
    rd(3, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(sys_rst === 1'b0 && irq === 1'b0, "R1 outputs low", {sys_rst, irq}, 0);
    @(negedge clk);

    // timeout sweeps
    for (int v = 64; v < 128; v++) run_timeout(v, 0, v & 1);
    for (int v = 64; v < 128; v++) run_timeout(v, 1, (v >> 1) & 1);
    run_timeout(64, 2, 1); run_timeout(65, 2, 1); run_timeout(100, 2, 0); run_timeout(127, 2, 1);
    run_timeout(64, 3, 0); run_timeout(90, 3, 1); run_timeout(127, 3, 1);
    rd(0, d); chk(d == 0, "R8 stopped after pulse", d, 0);
    rd(2, d); chk(d == 16'h7F, "R8 config default after pulse", d, 'h7F);

    // R5 window
    wr(2, 'h50); wr(0, 1); wr(1, 'h70); #1;
    chk(sys_rst === 1'b1, "R5 early refresh bites", sys_rst, 1);
    @(negedge clk);
    wr(2, 'h50); wr(0, 1); poll_cnt('h51); wr(1, 'h7F); #1;
    chk(sys_rst === 1'b1, "R5 refresh at window+1 bites", sys_rst, 1);
    @(negedge clk);
    wr(2, 'h50); wr(0, 1); poll_cnt('h50); wr(1, 'h7F);
    rd(1, d);
    chk(sys_rst === 1'b0, "R5 refresh at window accepted", sys_rst, 0);
    chk(d[6:0] == 7'h7F, "R5 reload value", d[6:0], 'h7F);
    repeat (3) @(negedge clk); rd(1, d);
    chk(d[6:0] == 7'h7F, "R2 phase restart hold", d[6:0], 'h7F);
    @(negedge clk); rd(1, d);
    chk(d[6:0] == 7'h7E, "R2 first decrement after reload", d[6:0], 'h7E);
    // R4 low write
    wr(2, 'h7F); wr(1, 'h3F); #1;
    chk(sys_rst === 1'b1, "R4 low value bites", sys_rst, 1);
    @(negedge clk);

    // R6 sticky enable
    wr(2, (3 << 7) | 'h7F); wr(0, 1); wr(0, 0);
    rd(0, d); chk(d[0] == 1'b1, "R6 start bit 0 ignored", d[0], 1);
    repeat (39) @(negedge clk);
    rd(1, d); chk(d[6:0] == 7'h7E, "R6 still counting", d[6:0], 'h7E);
    wr(1, 0); #1; chk(sys_rst === 1'b1, "R4 zero write bites", sys_rst, 1);
    @(negedge clk);

    // R10 / R6 bad start
    wr(1, 'h30); rd(1, d);
    chk(sys_rst === 1'b0 && d[6:0] == 7'h30, "R10 stopped load below floor", d[6:0], 'h30);
    wr(0, 1); #1; chk(sys_rst === 1'b1, "R6 start with low counter bites", sys_rst, 1);
    @(negedge clk);

    // R7 flag clear
    wr(2, (1 << 9) | (3 << 7) | 'h7F); wr(1, 'h41); wr(0, 1);
    repeat (32) @(negedge clk); #1;
    chk(irq === 1'b1, "R7 irq at floor", irq, 1);
    wr(3, 0); #1; chk(irq === 1'b1, "R7 status write 0 ignored", irq, 1);
    wr(3, 1); rd(3, d);
    chk(irq === 1'b0 && d == 0, "R7 status write 1 clears", d, 0);
    repeat (30) @(negedge clk); #1;
    chk(sys_rst === 1'b1, "R3 timeout after cleared flag", sys_rst, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule